// File: doc/BRIEF.md
# Receive Buffer with Level-Driven Request-to-Send

This block is the receive-side character store for an asynchronous serial port. The deserializer hands it one character at a time, with three error flags: parity, framing and break. It keeps up to 64 such entries in arrival order. The host sees the oldest entry at all times and removes it with a one-cycle read strobe. The block reports the fill level, a data-available flag and an active-low DMA-style ready indication.

The block also drives the active-low request-to-send line. In automatic mode a hysteresis state follows the fill level. The state sets when the level reaches a programmable halt threshold and clears when the level drains to a programmable resume threshold. The line follows that state with a fixed latency of two baud-clock ticks. Because the remote sender may already be part-way through a character when the line drops, the store keeps accepting characters above the halt level until it is completely full. In manual mode the line simply mirrors an inverted control bit.

A synchronous flush empties the store without touching the configuration inputs.

Top module: `rx_fifo_rts`

## Requirements
- R1: After reset: count_o is 0, data_ready_o is 0, rxrdy_no is 1, overrun_o is 0 and rts_no is 1.
- R2: Entries are read back in write order. rd_data_o, rd_perr_o, rd_ferr_o and rd_brk_o always show the oldest entry. count_o tracks the number of stored entries, from 0 to 64.
- R3: A write while count_o is 64 is discarded and leaves the contents and count unchanged, even if a read happens in the same cycle. It sets overrun_o, which stays set until flush or reset.
- R4: A read strobe while the store is empty is ignored, and count_o stays 0.
- R5: data_ready_o is 1 exactly when count_o is nonzero.
- R6: rxrdy_no goes low when the count reaches halt_lvl_i. It returns high only when the store becomes empty.
- R7: In automatic mode, the halt state sets when the count is at or above halt_lvl_i. It clears when the count is at or below resume_lvl_i, and holds its value in between. Setting takes priority over clearing.
- R8: In automatic mode, rts_no changes only on clocks where baud_tick_i is 1. It takes the halt state that was sampled at the previous tick (1 = halted, line high). A level change therefore reaches the pin on the second tick after it.
- R9: Characters that arrive after the halt level is reached are still stored, up to 64 entries.
- R10: Reading the last entry out of a halted store brings rts_no low two ticks later, for any resume level.
- R11: With automatic mode off, rts_no equals the inverse of rts_manual_i one clock later.
- R12: flush_i empties the store, clears overrun_o and sets rxrdy_no high. A write in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle baud-clock enable |
| flush_i | input | 1 | Synchronous store clear |
| wr_valid_i | input | 1 | Character strobe from the deserializer |
| wr_data_i | input | 8 | Received character |
| wr_perr_i | input | 1 | Parity error for the character |
| wr_ferr_i | input | 1 | Framing error for the character |
| wr_brk_i | input | 1 | Break indication for the character |
| rd_i | input | 1 | Host read strobe; pops the oldest entry |
| rts_manual_i | input | 1 | Manual control bit; 1 drives the line low |
| auto_rts_en_i | input | 1 | Selects level-driven control of the line |
| halt_lvl_i | input | 7 | Halt threshold, 1 to 64 |
| resume_lvl_i | input | 7 | Resume threshold, below halt |
| rd_data_o | output | 8 | Oldest stored character |
| rd_perr_o | output | 1 | Parity flag of the oldest entry |
| rd_ferr_o | output | 1 | Framing flag of the oldest entry |
| rd_brk_o | output | 1 | Break flag of the oldest entry |
| count_o | output | 7 | Number of stored entries |
| data_ready_o | output | 1 | Store not empty |
| rxrdy_no | output | 1 | DMA ready, active low |
| overrun_o | output | 1 | Sticky overflow flag |
| rts_no | output | 1 | Request to send, active low |

## Verification
The bench sweeps the store from empty to full and back under several threshold pairs, including a halt level of 1, a halt level equal to the depth, and a resume level of zero. After each step it compares the count, ready flags and line against an arithmetic hysteresis model. A design that compared with the wrong inequality would move the line one character early or late. A design that lacked hysteresis would release the line as soon as the level dipped below halt.

The latency test holds the baud tick off across a threshold crossing. This catches a line that reacts to the clock rather than to ticks, or that reacts after one tick instead of two. Writing into a full store with a different byte, then draining it, exposes a design that overwrote the last entry or miscounted. Reading from an empty store exposes count underflow.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rxf_entry_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  rxf_entry_t    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output rxf_entry_t    rdata_o
);
  rxf_entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_valid_i,
  input  logic          rd_i,
  input  logic [CW-1:0] halt_lvl_i,
  output logic          push_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_d_o,
  output logic          overrun_o,
  output logic          rxrdy_no
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_q, rxrdy_nq, push, pop;

  assign push = wr_valid_i && (cnt_q != FULL) && !flush_i;
  assign pop  = rd_i && (cnt_q != '0) && !flush_i;

  always_comb begin
    cnt_d = cnt_q;
    if (flush_i) cnt_d = '0;
    else if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
      rxrdy_nq <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      if (flush_i) begin
        wptr_q <= '0;
        rptr_q <= '0;
        ovr_q  <= 1'b0;
      end else begin
        if (push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
        if (pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
        if (wr_valid_i && cnt_q == FULL) ovr_q <= 1'b1;
      end
      // sticky until drained
      if (cnt_d == '0) rxrdy_nq <= 1'b1;
      else if (cnt_d >= halt_lvl_i) rxrdy_nq <= 1'b0;
    end
  end

  assign push_o    = push;
  assign wptr_o    = wptr_q;
  assign rptr_o    = rptr_q;
  assign cnt_o     = cnt_q;
  assign cnt_d_o   = cnt_d;
  assign overrun_o = ovr_q;
  assign rxrdy_no  = rxrdy_nq;
endmodule

// File: rtl/rxf_rts.sv
module rxf_rts #(
  parameter int unsigned CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          baud_tick_i,
  input  logic          auto_en_i,
  input  logic          manual_i,
  input  logic [CW-1:0] cnt_d_i,
  input  logic [CW-1:0] halt_lvl_i,
  input  logic [CW-1:0] resume_lvl_i,
  output logic          rts_no
);
  logic halt_q, stage_q, rts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q  <= 1'b0;
      stage_q <= 1'b1;
      rts_q   <= 1'b1;
    end else begin
      if (cnt_d_i >= halt_lvl_i) halt_q <= 1'b1;
      else if (cnt_d_i <= resume_lvl_i) halt_q <= 1'b0;
      // two-tick pipeline from level state to pin
      if (baud_tick_i) stage_q <= halt_q;
      if (!auto_en_i) rts_q <= !manual_i;
      else if (baud_tick_i) rts_q <= stage_q;
    end
  end

  assign rts_no = rts_q;
endmodule

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              flush_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_perr_i,
  input  logic              wr_ferr_i,
  input  logic              wr_brk_i,
  input  logic              rd_i,
  input  logic              rts_manual_i,
  input  logic              auto_rts_en_i,
  input  logic [CW-1:0]     halt_lvl_i,
  input  logic [CW-1:0]     resume_lvl_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_perr_o,
  output logic              rd_ferr_o,
  output logic              rd_brk_o,
  output logic [CW-1:0]     count_o,
  output logic              data_ready_o,
  output logic              rxrdy_no,
  output logic              overrun_o,
  output logic              rts_no
);
  logic          push;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_d;
  rxf_entry_t    wentry, rentry;

  assign wentry = '{brk: wr_brk_i, ferr: wr_ferr_i, perr: wr_perr_i, data: wr_data_i};

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .wr_valid_i (wr_valid_i),
    .rd_i       (rd_i),
    .halt_lvl_i (halt_lvl_i),
    .push_o     (push),
    .wptr_o     (wptr),
    .rptr_o     (rptr),
    .cnt_o      (cnt),
    .cnt_d_o    (cnt_d),
    .overrun_o  (overrun_o),
    .rxrdy_no   (rxrdy_no)
  );

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (wptr),
    .wdata_i (wentry),
    .raddr_i (rptr),
    .rdata_o (rentry)
  );

  rxf_rts #(.CW(CW)) u_rts (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .baud_tick_i  (baud_tick_i),
    .auto_en_i    (auto_rts_en_i),
    .manual_i     (rts_manual_i),
    .cnt_d_i      (cnt_d),
    .halt_lvl_i   (halt_lvl_i),
    .resume_lvl_i (resume_lvl_i),
    .rts_no       (rts_no)
  );

  assign rd_data_o    = rentry.data;
  assign rd_perr_o    = rentry.perr;
  assign rd_ferr_o    = rentry.ferr;
  assign rd_brk_o     = rentry.brk;
  assign count_o      = cnt;
  assign data_ready_o = (cnt != '0);
endmodule

// File: rtl/rx_fifo_rts_chk.sv
module rx_fifo_rts_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          baud_tick_i,
  input logic          flush_i,
  input logic          wr_valid_i,
  input logic          rd_i,
  input logic          rts_manual_i,
  input logic          auto_rts_en_i,
  input logic [CW-1:0] halt_lvl_i,
  input logic [CW-1:0] count_o,
  input logic          data_ready_o,
  input logic          rxrdy_no,
  input logic          overrun_o,
  input logic          rts_no
);
  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  // R3
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && count_o == CW'(DEPTH) && !rd_i && !flush_i)
      |=> (count_o == CW'(DEPTH) && overrun_o));

  // R4
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && count_o == '0 && !wr_valid_i) |=> (count_o == '0));

  // R5
  last_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && count_o == CW'(1) && !wr_valid_i) |=> !data_ready_o);

  // R6
  rxrdy_trigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rxrdy_no) && $stable(halt_lvl_i)) |-> (count_o >= halt_lvl_i));

  // R8
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && !baud_tick_i) |=> $stable(rts_no));

  // R11
  manual_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_rts_en_i |=> (rts_no == !$past(rts_manual_i)));
endmodule

bind rx_fifo_rts rx_fifo_rts_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .baud_tick_i   (baud_tick_i),
  .flush_i       (flush_i),
  .wr_valid_i    (wr_valid_i),
  .rd_i          (rd_i),
  .rts_manual_i  (rts_manual_i),
  .auto_rts_en_i (auto_rts_en_i),
  .halt_lvl_i    (halt_lvl_i),
  .count_o       (count_o),
  .data_ready_o  (data_ready_o),
  .rxrdy_no      (rxrdy_no),
  .overrun_o     (overrun_o),
  .rts_no        (rts_no)
);

// File: tb/tb_rx_fifo_rts.sv
module tb_rx_fifo_rts;
  localparam int DEPTH = 64;

  logic       clk_i = 0, rst_ni = 0;
  logic       baud_tick_i = 0, flush_i = 0, wr_valid_i = 0, rd_i = 0;
  logic [7:0] wr_data_i = 0;
  logic       wr_perr_i = 0, wr_ferr_i = 0, wr_brk_i = 0;
  logic       rts_manual_i = 0, auto_rts_en_i = 0;
  logic [6:0] halt_lvl_i = 7'd8, resume_lvl_i = 7'd3;
  logic [7:0] rd_data_o;
  logic       rd_perr_o, rd_ferr_o, rd_brk_o;
  logic [6:0] count_o;
  logic       data_ready_o, rxrdy_no, overrun_o, rts_no;

  int checks = 0, failures = 0;

  always #2 clk_i = ~clk_i;

  rx_fifo_rts dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk_i) baud_tick_i = 1;
      @(negedge clk_i) baud_tick_i = 0;
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] f);
    @(negedge clk_i);
    wr_valid_i = 1; wr_data_i = d; {wr_brk_i, wr_ferr_i, wr_perr_i} = f;
    @(negedge clk_i) wr_valid_i = 0;
  endtask

  task automatic pop();
    @(negedge clk_i) rd_i = 1;
    @(negedge clk_i) rd_i = 0;
  endtask

  task automatic flush();
    @(negedge clk_i) flush_i = 1;
    @(negedge clk_i) flush_i = 0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  task automatic sweep(input int h, input int r);
    int cnt = 0; bit hs = 0; bit rx = 1;
    halt_lvl_i = 7'(h); resume_lvl_i = 7'(r); auto_rts_en_i = 1;
    flush();
    chk(overrun_o == 0, "R12 overrun cleared", overrun_o, 0);
    chk(count_o == 0, "R12 count cleared", count_o, 0);
    ticks(2);
    chk(rts_no == hs, "R7 rts after flush", rts_no, hs);
    for (int i = 0; i < DEPTH; i++) begin
      push(pat(i), 3'(i));
      cnt++;
      if (cnt >= h) hs = 1; else if (cnt <= r) hs = 0;
      if (cnt == 0) rx = 1; else if (cnt >= h) rx = 0;
      ticks(2);
      chk(count_o == 7'(cnt), "R9 count on fill", count_o, cnt);
      chk(rts_no == hs, "R7 rts on fill", rts_no, hs);
      chk(rxrdy_no == rx, "R6 rxrdy on fill", rxrdy_no, rx);
      chk(data_ready_o == 1, "R5 ready on fill", data_ready_o, 1);
    end
    push(8'hA5, 3'b111);
    chk(count_o == 7'd64, "R3 count at overrun", count_o, 64);
    chk(overrun_o == 1, "R3 overrun set", overrun_o, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk(rd_data_o == pat(i), "R2 data order", rd_data_o, pat(i));
      chk({rd_brk_o, rd_ferr_o, rd_perr_o} == 3'(i), "R2 flags", {rd_brk_o, rd_ferr_o, rd_perr_o}, i % 8);
      pop();
      cnt--;
      if (cnt >= h) hs = 1; else if (cnt <= r) hs = 0;
      if (cnt == 0) rx = 1; else if (cnt >= h) rx = 0;
      ticks(2);
      chk(count_o == 7'(cnt), "R2 count on drain", count_o, cnt);
      chk(rts_no == hs, "R7 rts on drain", rts_no, hs);
      chk(rxrdy_no == rx, "R6 rxrdy on drain", rxrdy_no, rx);
      chk(overrun_o == 1, "R3 overrun sticky", overrun_o, 1);
    end
    chk(rts_no == 0, "R10 rts low when empty", rts_no, 0);
    chk(data_ready_o == 0, "R5 ready low when empty", data_ready_o, 0);
    pop();
    chk(count_o == 0, "R4 empty read ignored", count_o, 0);
  endtask

  initial begin
    cyc(2);
    chk(rts_no == 1, "R1 rts in reset", rts_no, 1);
    rst_ni = 1;
    cyc(1);
    chk(count_o == 0, "R1 count", count_o, 0);
    chk(data_ready_o == 0, "R1 ready", data_ready_o, 0);
    chk(rxrdy_no == 1, "R1 rxrdy", rxrdy_no, 1);
    chk(overrun_o == 0, "R1 overrun", overrun_o, 0);
    chk(rts_no == 1, "R1 rts", rts_no, 1);

    // R4: read while empty
    pop();
    chk(count_o == 0, "R4 count stays 0", count_o, 0);

    // R11: manual mode
    @(negedge clk_i) rts_manual_i = 1;
    @(negedge clk_i);
    chk(rts_no == 0, "R11 manual low", rts_no, 0);
    @(negedge clk_i) rts_manual_i = 0;
    @(negedge clk_i);
    chk(rts_no == 1, "R11 manual high", rts_no, 1);

    // R8: two-tick latency, halt 8 resume 3
    auto_rts_en_i = 1; halt_lvl_i = 7'd8; resume_lvl_i = 7'd3;
    ticks(2);
    chk(rts_no == 0, "R8 auto low empty", rts_no, 0);
    for (int i = 0; i < 8; i++) push(8'(i), 3'b000);
    cyc(5);
    chk(rts_no == 0, "R8 no tick no change", rts_no, 0);
    ticks(1);
    chk(rts_no == 0, "R8 one tick no change", rts_no, 0);
    ticks(1);
    chk(rts_no == 1, "R8 second tick halts", rts_no, 1);
    push(8'h11, 3'b000); push(8'h22, 3'b000);
    chk(count_o == 10, "R9 bytes past halt", count_o, 10);
    for (int i = 0; i < 6; i++) pop();
    ticks(2);
    chk(rts_no == 1, "R7 held above resume", rts_no, 1);
    pop();
    ticks(2);
    chk(rts_no == 0, "R7 released at resume", rts_no, 0);

    // R12: flush drops simultaneous write
    @(negedge clk_i) begin flush_i = 1; wr_valid_i = 1; end
    @(negedge clk_i) begin flush_i = 0; wr_valid_i = 0; end
    chk(count_o == 0, "R12 flush with write", count_o, 0);
    chk(rxrdy_no == 1, "R12 rxrdy high", rxrdy_no, 1);

    // R10: last read with resume 0
    halt_lvl_i = 7'd2; resume_lvl_i = 7'd0;
    push(8'h5A, 3'b001); push(8'h6B, 3'b010);
    ticks(2);
    chk(rts_no == 1, "R10 halted", rts_no, 1);
    pop(); ticks(2);
    chk(rts_no == 1, "R10 one left", rts_no, 1);
    pop(); ticks(2);
    chk(rts_no == 0, "R10 last read releases", rts_no, 0);

    sweep(8, 3);
    sweep(1, 0);
    sweep(64, 63);
    sweep(32, 16);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule